// File: doc/BRIEF.md
# DMA Channel Control Sequencer

This block is the per-channel control logic of a DMA engine. Software programs a 32-bit control word through a simple register bus. The control word arms the channel, requests a software start, selects whether the channel keeps running while the system is in standby, and turns on descriptor chaining. When the channel is armed, a hardware trigger or a pending software trigger produces a one-cycle start pulse for the data mover. The channel then reports busy until the mover signals that the block is done or aborted. Either event clears the arm bit in hardware. If software clears the arm bit while a block is running, the block is suspended and the mover is told to pause. Writing the bit back to 1 resumes the block.

When chaining is enabled and the channel is idle, the block reads the next descriptor from the address held in its next-pointer register. It issues a request on the descriptor port. On the response, it reloads the next pointer from the returned value and re-arms the channel, which then waits for another trigger. An all-ones next pointer marks the end of the list. In that case no request is issued, a sticky end-of-list flag is raised, and chaining is turned off.

The sequencing state machine has four states. SEQ_IDLE moves to SEQ_ARMED when the arm bit is 1. SEQ_ARMED moves back to SEQ_IDLE when the arm bit is cleared, and moves to SEQ_BUSY on an accepted trigger. SEQ_BUSY moves to SEQ_IDLE on done or abort, and moves to SEQ_SUSP when the arm bit is cleared. SEQ_SUSP moves to SEQ_BUSY when the arm bit is set again, and moves to SEQ_IDLE on abort. The descriptor state machine has two states. LNK_IDLE moves to LNK_REQ when a fetch starts with a non-null pointer. LNK_REQ moves back to LNK_IDLE on the response.

Top module: `dma_chan_ctrl`

## Requirements
- R1: After reset, the control word reads 0x0000_0000, the next pointer reads 0xFFFF_FFFF, the status word reads 0, and busy, blk_start, blk_pause, desc_req and ll_flag are all 0.
- R2: Address map and control fields. The control word is at byte address 0x50 + CHAN_IDX*0x50, the next pointer is 4 bytes above it, and the status word is 8 bytes above it. Control bit 0 is arm, bit 8 is chain enable, bit 16 is software trigger and bit 24 is run-in-standby. Bit 16 always reads back as 0.
- R3: While the channel is armed, a high hw_trig produces exactly one blk_start pulse. busy is 1 from the next cycle onwards.
- R4: Writing 1 to bit 16 gives one start. This also works in the same write that sets arm. A software trigger written while the arm bit is 0 is dropped.
- R5: blk_done or blk_abort during a block clears the arm bit and drops busy in the following cycle.
- R6: Writing arm = 0 during a block keeps busy at 1 and raises blk_pause. Writing arm = 1 again clears blk_pause and keeps busy at 1.
- R7: While standby is 1 and run-in-standby is 0, no block starts, and a running block sees blk_pause = 1. With run-in-standby = 1, triggers are accepted during standby.
- R8: With chain enable = 1 and the channel idle and not armed, desc_req rises with desc_addr equal to the next pointer. On desc_ack, the next pointer takes desc_next and the arm bit becomes 1.
- R9: With chain enable = 1 and a next pointer of 0xFFFF_FFFF, no descriptor request is made. ll_flag (status bit 0) is set and chain enable is cleared.
- R10: ll_flag is cleared by writing 1 to status bit 0. Writing 0 leaves it unchanged.
- R11: While wr_prot is 1, bus writes change no register.
- R12: When a hardware clear of the arm bit and a software write of arm = 1 happen in the same cycle, the arm bit ends at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| wr_prot | input | 1 | Write protection; register writes are ignored while high |
| hw_trig | input | 1 | Selected hardware start trigger |
| standby | input | 1 | System standby indication |
| blk_done | input | 1 | Data mover finished the block |
| blk_abort | input | 1 | Data mover aborted the block |
| desc_req | output | 1 | Descriptor fetch request |
| desc_addr | output | 32 | Descriptor fetch address |
| desc_ack | input | 1 | Descriptor fetch response valid |
| desc_next | input | 32 | Next pointer carried by the fetched descriptor |
| blk_start | output | 1 | One-cycle start pulse to the data mover |
| blk_pause | output | 1 | Data mover must hold the current block |
| busy | output | 1 | A block is running or suspended |
| ll_flag | output | 1 | End-of-list reached (sticky) |

## Verification
The hardest conditions to reach from the ports are the end of a chain and the same-cycle conflict between hardware and software. For the end of a chain, the bench sets a real pointer and enables chaining. It then answers the resulting descriptor request with an all-ones pointer and runs the re-armed block to completion. At that point the idle channel must detect the null pointer without issuing a second request. For the conflict case, the bench drives the software write of arm = 1 and blk_done onto the same clock edge. The suspend and standby paths are reached by changing the control word while a started block is still held busy.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
    localparam int CTRL_W     = 32;
    localparam int ARM_BIT    = 0;
    localparam int CHAIN_BIT  = 8;
    localparam int SWTRG_BIT  = 16;
    localparam int RSB_BIT    = 24;
    localparam int PTR_OFS    = 4;
    localparam int STAT_OFS   = 8;
    localparam logic [CTRL_W-1:0] NULL_PTR = '1;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_ARMED,
        SEQ_BUSY,
        SEQ_SUSP
    } seq_state_e;

    typedef enum logic {
        LNK_IDLE,
        LNK_REQ
    } lnk_state_e;
endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
    import dma_chan_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 12'h050
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CTRL_W-1:0] bus_wdata,
    output logic [CTRL_W-1:0] bus_rdata,
    input  logic              wr_prot,
    input  logic              hw_arm_set,
    input  logic              hw_arm_clr,
    input  logic              hw_chain_clr,
    input  logic              hw_end_set,
    input  logic              hw_ptr_load,
    input  logic [CTRL_W-1:0] hw_ptr_val,
    output logic              arm_q,
    output logic              chain_q,
    output logic              rsb_q,
    output logic              sw_trig,
    output logic [CTRL_W-1:0] ptr_q,
    output logic              end_q
);
    localparam logic [ADDR_W-1:0] PTR_ADDR  = CTRL_ADDR + ADDR_W'(PTR_OFS);
    localparam logic [ADDR_W-1:0] STAT_ADDR = CTRL_ADDR + ADDR_W'(STAT_OFS);

    logic wr_ok, wr_ctrl, wr_ptr, wr_stat;

    always_comb begin
        wr_ok   = bus_wr && !wr_prot;
        wr_ctrl = wr_ok && (bus_addr == CTRL_ADDR);
        wr_ptr  = wr_ok && (bus_addr == PTR_ADDR);
        wr_stat = wr_ok && (bus_addr == STAT_ADDR);
    end

    // Hardware actions win over software writes on the same edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arm_q   <= 1'b0;
            chain_q <= 1'b0;
            rsb_q   <= 1'b0;
            sw_trig <= 1'b0;
            ptr_q   <= NULL_PTR;
            end_q   <= 1'b0;
        end else begin
            if (hw_arm_clr)
                arm_q <= 1'b0;
            else if (hw_arm_set)
                arm_q <= 1'b1;
            else if (wr_ctrl)
                arm_q <= bus_wdata[ARM_BIT];

            if (hw_chain_clr)
                chain_q <= 1'b0;
            else if (wr_ctrl)
                chain_q <= bus_wdata[CHAIN_BIT];

            if (wr_ctrl)
                rsb_q <= bus_wdata[RSB_BIT];

            sw_trig <= wr_ctrl && bus_wdata[SWTRG_BIT];

            if (hw_ptr_load)
                ptr_q <= hw_ptr_val;
            else if (wr_ptr)
                ptr_q <= bus_wdata;

            if (hw_end_set)
                end_q <= 1'b1;
            else if (wr_stat && bus_wdata[0])
                end_q <= 1'b0;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == CTRL_ADDR) begin
            bus_rdata[ARM_BIT]   = arm_q;
            bus_rdata[CHAIN_BIT] = chain_q;
            bus_rdata[RSB_BIT]   = rsb_q;
        end else if (bus_addr == PTR_ADDR) begin
            bus_rdata = ptr_q;
        end else if (bus_addr == STAT_ADDR) begin
            bus_rdata[0] = end_q;
        end
    end
endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
    import dma_chan_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic arm_q,
    input  logic hw_trig,
    input  logic sw_trig,
    input  logic halt,
    input  logic blk_done,
    input  logic blk_abort,
    output logic blk_start,
    output logic busy,
    output logic blk_pause,
    output logic arm_clr,
    output logic seq_idle
);
    seq_state_e state_q, state_d;
    logic       pend_q;
    logic       fire;

    always_comb fire = (hw_trig || pend_q) && !halt;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE:  if (arm_q) state_d = SEQ_ARMED;
            SEQ_ARMED: begin
                if (!arm_q)    state_d = SEQ_IDLE;
                else if (fire) state_d = SEQ_BUSY;
            end
            SEQ_BUSY: begin
                if (blk_done || blk_abort) state_d = SEQ_IDLE;
                else if (!arm_q)           state_d = SEQ_SUSP;
            end
            SEQ_SUSP: begin
                if (blk_abort)  state_d = SEQ_IDLE;
                else if (arm_q) state_d = SEQ_BUSY;
            end
            default: state_d = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        blk_start = 1'b0;
        busy      = 1'b0;
        blk_pause = 1'b0;
        arm_clr   = 1'b0;
        seq_idle  = 1'b0;
        unique case (state_q)
            SEQ_IDLE:  seq_idle  = 1'b1;
            SEQ_ARMED: blk_start = arm_q && fire;
            SEQ_BUSY: begin
                busy      = 1'b1;
                blk_pause = halt;
                arm_clr   = blk_done || blk_abort;
            end
            SEQ_SUSP: begin
                busy      = 1'b1;
                blk_pause = 1'b1;
                arm_clr   = blk_abort;
            end
            default: seq_idle = 1'b1;
        endcase
    end

    // A software trigger stays pending until used or the channel is disarmed.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pend_q <= 1'b0;
        else if (sw_trig)
            pend_q <= 1'b1;
        else if (blk_start)
            pend_q <= 1'b0;
        else if (state_q == SEQ_IDLE && !arm_q)
            pend_q <= 1'b0;
    end
endmodule

// File: rtl/dma_chan_link.sv
module dma_chan_link
    import dma_chan_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chain_q,
    input  logic              arm_q,
    input  logic              seq_idle,
    input  logic              halt,
    input  logic [CTRL_W-1:0] ptr_q,
    input  logic              desc_ack,
    input  logic [CTRL_W-1:0] desc_next,
    output logic              desc_req,
    output logic [CTRL_W-1:0] desc_addr,
    output logic              arm_set,
    output logic              chain_clr,
    output logic              end_set,
    output logic              ptr_load,
    output logic [CTRL_W-1:0] ptr_val
);
    lnk_state_e        state_q, state_d;
    logic [CTRL_W-1:0] addr_q;
    logic              go, at_end;

    always_comb begin
        go     = chain_q && !arm_q && seq_idle && !halt;
        at_end = (ptr_q == NULL_PTR);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LNK_IDLE: if (go && !at_end) state_d = LNK_REQ;
            LNK_REQ:  if (desc_ack)      state_d = LNK_IDLE;
            default:  state_d = LNK_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LNK_IDLE;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == LNK_IDLE && state_d == LNK_REQ)
                addr_q <= ptr_q;
        end
    end

    always_comb begin
        desc_req  = 1'b0;
        arm_set   = 1'b0;
        chain_clr = 1'b0;
        end_set   = 1'b0;
        ptr_load  = 1'b0;
        unique case (state_q)
            LNK_IDLE: begin
                end_set   = go && at_end;
                chain_clr = go && at_end;
            end
            LNK_REQ: begin
                desc_req = 1'b1;
                arm_set  = desc_ack;
                ptr_load = desc_ack;
            end
            default: ;
        endcase
        desc_addr = addr_q;
        ptr_val   = desc_next;
    end
endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
    import dma_chan_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int CHAN_IDX  = 0,
    parameter int BASE_STEP = 'h50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              wr_prot,
    input  logic              hw_trig,
    input  logic              standby,
    input  logic              blk_done,
    input  logic              blk_abort,
    output logic              desc_req,
    output logic [31:0]       desc_addr,
    input  logic              desc_ack,
    input  logic [31:0]       desc_next,
    output logic              blk_start,
    output logic              blk_pause,
    output logic              busy,
    output logic              ll_flag
);
    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(BASE_STEP * (CHAN_IDX + 1));

    logic              arm_q, chain_q, rsb_q, sw_trig;
    logic [CTRL_W-1:0] ptr_q;
    logic              halt, seq_idle;
    logic              arm_set, arm_clr, chain_clr, end_set, ptr_load;
    logic [CTRL_W-1:0] ptr_val;

    always_comb halt = standby && !rsb_q;

    dma_chan_regs #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .wr_prot(wr_prot),
        .hw_arm_set(arm_set), .hw_arm_clr(arm_clr), .hw_chain_clr(chain_clr),
        .hw_end_set(end_set), .hw_ptr_load(ptr_load), .hw_ptr_val(ptr_val),
        .arm_q(arm_q), .chain_q(chain_q), .rsb_q(rsb_q), .sw_trig(sw_trig),
        .ptr_q(ptr_q), .end_q(ll_flag)
    );

    dma_chan_seq u_seq (
        .clk(clk), .rst_n(rst_n),
        .arm_q(arm_q), .hw_trig(hw_trig), .sw_trig(sw_trig), .halt(halt),
        .blk_done(blk_done), .blk_abort(blk_abort),
        .blk_start(blk_start), .busy(busy), .blk_pause(blk_pause),
        .arm_clr(arm_clr), .seq_idle(seq_idle)
    );

    dma_chan_link u_link (
        .clk(clk), .rst_n(rst_n),
        .chain_q(chain_q), .arm_q(arm_q), .seq_idle(seq_idle), .halt(halt),
        .ptr_q(ptr_q), .desc_ack(desc_ack), .desc_next(desc_next),
        .desc_req(desc_req), .desc_addr(desc_addr),
        .arm_set(arm_set), .chain_clr(chain_clr), .end_set(end_set),
        .ptr_load(ptr_load), .ptr_val(ptr_val)
    );
endmodule

// File: rtl/dma_chan_ctrl_chk.sv
module dma_chan_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        blk_start,
    input logic        busy,
    input logic        blk_pause,
    input logic        blk_done,
    input logic        blk_abort,
    input logic        standby,
    input logic        wr_prot,
    input logic        desc_req,
    input logic [31:0] desc_addr,
    input logic        ll_flag,
    input logic        arm_q,
    input logic        chain_q,
    input logic        rsb_q
);
    assert_start_from_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        blk_start |-> !busy);

    assert_start_then_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        blk_start |=> busy);

    assert_abort_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && blk_abort) |=> (!busy && !arm_q));

    assert_suspend_pauses_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !arm_q && !blk_done && !blk_abort) |=> blk_pause);

    assert_no_start_halted_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (standby && !rsb_q) |-> !blk_start);

    assert_no_null_fetch_R9: assert property (@(posedge clk) disable iff (!rst_n)
        desc_req |-> (desc_addr != 32'hFFFF_FFFF));

    assert_end_drops_chain_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ll_flag) |-> !chain_q);

    assert_protect_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_prot |=> $stable(rsb_q));
endmodule

bind dma_chan_ctrl dma_chan_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .blk_start(blk_start), .busy(busy),
    .blk_pause(blk_pause), .blk_done(blk_done), .blk_abort(blk_abort),
    .standby(standby), .wr_prot(wr_prot), .desc_req(desc_req),
    .desc_addr(desc_addr), .ll_flag(ll_flag), .arm_q(arm_q),
    .chain_q(chain_q), .rsb_q(rsb_q)
);

// File: tb/dma_chan_ctrl_test.sv
module dma_chan_ctrl_test;
    localparam logic [11:0] A_CTRL = 12'h050;
    localparam logic [11:0] A_PTR  = 12'h054;
    localparam logic [11:0] A_STAT = 12'h058;
    localparam logic [31:0] F_ARM   = 32'h0000_0001;
    localparam logic [31:0] F_CHAIN = 32'h0000_0100;
    localparam logic [31:0] F_SW    = 32'h0001_0000;
    localparam logic [31:0] F_RSB   = 32'h0100_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        wr_prot = 1'b0, hw_trig = 1'b0, standby = 1'b0;
    logic        blk_done = 1'b0, blk_abort = 1'b0;
    logic        desc_req, desc_ack = 1'b0;
    logic [31:0] desc_addr, desc_next = '0;
    logic        blk_start, blk_pause, busy, ll_flag;

    int checks = 0, errors = 0, starts = 0, reqs = 0;

    always #5 clk = ~clk;

    dma_chan_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wr_prot(wr_prot),
        .hw_trig(hw_trig), .standby(standby), .blk_done(blk_done),
        .blk_abort(blk_abort), .desc_req(desc_req), .desc_addr(desc_addr),
        .desc_ack(desc_ack), .desc_next(desc_next), .blk_start(blk_start),
        .blk_pause(blk_pause), .busy(busy), .ll_flag(ll_flag)
    );

    always @(posedge clk) begin
        if (rst_n) begin
            if (blk_start) starts++;
            if (desc_req)  reqs++;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic pulse_done;
        blk_done = 1'b1; @(negedge clk); blk_done = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rd(A_CTRL, d); chk("R1 ctrl", d, 32'h0);
        rd(A_PTR, d);  chk("R1 ptr", d, 32'hFFFF_FFFF);
        rd(A_STAT, d); chk("R1 stat", d, 32'h0);
        chk("R1 outs", {28'h0, busy, blk_start, blk_pause, desc_req}, 32'h0);
        chk("R1 flag", {31'h0, ll_flag}, 32'h0);
    endtask

    task automatic t_sw_readback;
        logic [31:0] d;
        int s0 = starts;
        wr(A_CTRL, F_SW | F_RSB);
        rd(A_CTRL, d); chk("R2 sw bit reads 0", d, F_RSB);
        tick(4);
        wr(A_CTRL, F_ARM);
        tick(4);
        chk("R4 dropped sw trigger", starts - s0, 0);
        wr(A_CTRL, 32'h0);
        tick(2);
    endtask

    task automatic t_hw_trig;
        logic [31:0] d;
        int s0 = starts;
        wr(A_CTRL, F_ARM);
        tick(3);
        chk("R3 no trigger no start", starts - s0, 0);
        hw_trig = 1'b1; @(negedge clk); hw_trig = 1'b0;
        chk("R3 one start", starts - s0, 1);
        chk("R3 busy", {31'h0, busy}, 1);
        tick(3);
        chk("R3 still one start", starts - s0, 1);
        pulse_done();
        chk("R5 done drops busy", {31'h0, busy}, 0);
        rd(A_CTRL, d); chk("R5 done clears arm", d, 32'h0);
    endtask

    task automatic t_sw_trig;
        logic [31:0] d;
        int s0 = starts;
        wr(A_CTRL, F_ARM | F_SW);
        tick(3);
        chk("R4 sw start", starts - s0, 1);
        chk("R4 busy", {31'h0, busy}, 1);
        blk_abort = 1'b1; @(negedge clk); blk_abort = 1'b0;
        chk("R5 abort drops busy", {31'h0, busy}, 0);
        rd(A_CTRL, d); chk("R5 abort clears arm", d, 32'h0);
    endtask

    task automatic t_suspend;
        wr(A_CTRL, F_ARM | F_SW);
        tick(3);
        wr(A_CTRL, 32'h0);
        tick(2);
        chk("R6 suspended busy", {31'h0, busy}, 1);
        chk("R6 suspended pause", {31'h0, blk_pause}, 1);
        wr(A_CTRL, F_ARM);
        tick(2);
        chk("R6 resumed pause", {31'h0, blk_pause}, 0);
        chk("R6 resumed busy", {31'h0, busy}, 1);
        pulse_done();
        chk("R5 done after resume", {31'h0, busy}, 0);
    endtask

    task automatic t_standby;
        int s0 = starts;
        standby = 1'b1;
        wr(A_CTRL, F_ARM | F_SW);
        tick(4);
        chk("R7 halted no start", starts - s0, 0);
        chk("R7 halted idle", {31'h0, busy}, 0);
        wr(A_CTRL, F_ARM | F_RSB);
        tick(3);
        chk("R7 run in standby start", starts - s0, 1);
        wr(A_CTRL, F_ARM);
        tick(1);
        chk("R7 halted block paused", {31'h0, blk_pause}, 1);
        standby = 1'b0;
        tick(1);
        chk("R7 pause lifted", {31'h0, blk_pause}, 0);
        pulse_done();
        tick(1);
    endtask

    task automatic t_chain;
        logic [31:0] d;
        int s0, r0;
        bit seen = 0;
        wr(A_PTR, 32'h0000_1000);
        wr(A_CTRL, F_CHAIN);
        for (int i = 0; i < 10 && !seen; i++) begin
            if (desc_req) seen = 1; else @(negedge clk);
        end
        chk("R8 request", {31'h0, desc_req}, 1);
        chk("R8 request addr", desc_addr, 32'h0000_1000);
        desc_next = 32'hFFFF_FFFF; desc_ack = 1'b1;
        @(negedge clk);
        desc_ack = 1'b0;
        tick(1);
        rd(A_CTRL, d); chk("R8 re-armed", d, F_CHAIN | F_ARM);
        rd(A_PTR, d);  chk("R8 pointer loaded", d, 32'hFFFF_FFFF);
        chk("R8 request done", {31'h0, desc_req}, 0);
        s0 = starts; r0 = reqs;
        hw_trig = 1'b1; @(negedge clk); hw_trig = 1'b0;
        chk("R8 chained start", starts - s0, 1);
        pulse_done();
        tick(3);
        rd(A_CTRL, d); chk("R9 chain cleared", d, 32'h0);
        rd(A_STAT, d); chk("R9 end flag", d, 32'h1);
        chk("R9 no null fetch", reqs - r0, 0);
        wr(A_STAT, 32'h0);
        rd(A_STAT, d); chk("R10 write 0 keeps", d, 32'h1);
        wr(A_STAT, 32'h1);
        rd(A_STAT, d); chk("R10 write 1 clears", d, 32'h0);
    endtask

    task automatic t_protect;
        logic [31:0] d;
        wr_prot = 1'b1;
        wr(A_CTRL, F_ARM | F_RSB | F_SW);
        wr(A_PTR, 32'h0000_2000);
        tick(3);
        rd(A_CTRL, d); chk("R11 ctrl unchanged", d, 32'h0);
        rd(A_PTR, d);  chk("R11 ptr unchanged", d, 32'hFFFF_FFFF);
        chk("R11 no block", {31'h0, busy}, 0);
        wr_prot = 1'b0;
    endtask

    task automatic t_priority;
        logic [31:0] d;
        wr(A_CTRL, F_ARM | F_SW);
        tick(3);
        chk("R12 running", {31'h0, busy}, 1);
        bus_wr = 1'b1; bus_addr = A_CTRL; bus_wdata = F_ARM; blk_done = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; blk_done = 1'b0;
        rd(A_CTRL, d); chk("R12 hardware clear wins", d, 32'h0);
        chk("R12 idle", {31'h0, busy}, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_sw_readback();
        t_hw_trig();
        t_sw_trig();
        t_suspend();
        t_standby();
        t_chain();
        t_protect();
        t_priority();
        tick(2);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule